// File: doc/BRIEF.md
# Per-Bit Direction Control Port

This block is an N-bit parallel port with no handshake. Each data line is set on its own as an input or an output by a direction register. The CPU writes that register with a separate control strobe. A data write loads the output register in any cycle. The pin drivers are enabled only on lines whose direction bit selects output.

A read returns one merged word. Lines configured as outputs give back the output register. Lines configured as inputs give back an input register. That register follows the synchronized pins while the active-low read strobe is high. It freezes as soon as the strobe is seen low, so the word stays stable for the whole read.

The CPU side uses plain single-cycle strobes rather than a valid/ready stream. The port never stalls, so there is no back-pressure to express. A write enable is accepted on every clock edge where it is high, and the read word is always valid.

The block also drives a ready line to a fixed level. When it serves as the first port, the line is low. When it serves as the second port, the line is low unless the companion port is in bidirectional mode. In that case the companion's ready value passes through unchanged.

Top module: `dpc_port`

## Requirements
- R1: While reset is asserted and after release with no writes: every direction bit is input, `pin_oe` is all zeros, `pin_out` is all zeros, and `rdy` is 0.
- R2: A clock edge with `data_wr_en` high loads `wr_data` into the output register. The value appears on `pin_out` right after that edge.
- R3: An edge with `data_wr_en` low leaves `pin_out` unchanged, and an edge with `dir_wr_en` low leaves `pin_oe` unchanged, whatever `wr_data` carries.
- R4: An edge with `dir_wr_en` high loads `wr_data` into the direction register (bit value 1 = input, 0 = output). Right after that edge, `pin_oe` equals the bitwise inverse of the written value.
- R5: For every bit, `rd_data` returns the output-register bit where the direction is output. It returns the input-register bit where the direction is input.
- R6: With `rd_n` high, a change on `pin_in` reaches the input bits of `rd_data` after exactly SYNC_STAGES+1 clock edges. With the default of 2 stages, that is 3 edges.
- R7: On an edge where `rd_n` is low, the input register does not update. Input bits of `rd_data` keep the value captured at the last edge with `rd_n` high. On the first edge with `rd_n` high again, the register reloads from the synchronizer.
- R8: Data and direction writes take effect while `rd_n` is low; no handshake gates them.
- R9: With `is_second` low, `rdy` is 0 for every value of `peer_bidir` and `peer_rdy`.
- R10: With `is_second` high, `rdy` is 0 when `peer_bidir` is low, and equals `peer_rdy` when `peer_bidir` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_wr_en | input | 1 | Load `wr_data` into the output register |
| dir_wr_en | input | 1 | Load `wr_data` into the direction register (1 = input) |
| wr_data | input | W | Write data shared by both write strobes |
| rd_n | input | 1 | Active-low read strobe, synchronous to `clk` |
| rd_data | output | W | Merged read word |
| pin_in | input | W | Pin levels seen from outside, asynchronous |
| pin_out | output | W | Output register driven towards the pins |
| pin_oe | output | W | Per-bit driver enable, 1 = drive |
| is_second | input | 1 | Block serves as the second port |
| peer_bidir | input | 1 | Companion port is in bidirectional mode |
| peer_rdy | input | 1 | Ready value supplied by the companion logic |
| rdy | output | 1 | Ready line |

## Verification
Register writes show on `pin_out`, `pin_oe` and the output bits of `rd_data` one edge after the strobe. A pin change needs three edges to reach the input bits: two synchronizer stages and the input register. The ready line is combinational and settles within the same cycle.

The bench changes inputs on the falling clock edge and compares on a later falling edge. It counts exactly one rising edge for writes and exactly three for pin changes. It also checks that the old input value is still present after one and two edges. Ready is checked a fraction of a cycle after its inputs move.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int DPC_SYNC_DEFAULT = 2;

  // per-bit merge: direction 1 selects the input side
  function automatic logic merge_bit(input logic dir_in, input logic out_b, input logic in_b);
    return dir_in ? in_b : out_b;
  endfunction
endpackage

// File: rtl/dpc_regs.sv
module dpc_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_wr_en,
  input  logic         dir_wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      out_q <= '0;
    end else begin
      if (dir_wr_en)  dir_q <= wr_data;
      if (data_wr_en) out_q <= wr_data;
    end
  end
endmodule

// File: rtl/dpc_in_sample.sv
module dpc_in_sample #(
  parameter int W      = 8,
  parameter int STAGES = dpc_pkg::DPC_SYNC_DEFAULT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] in_q
);
  localparam int LAST = STAGES - 1;
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= pin_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  // capture only while the read strobe is inactive
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    in_q <= '0;
    else if (rd_n) in_q <= chain[LAST];
  end
endmodule

// File: rtl/dpc_merge.sv
module dpc_merge #(
  parameter int W = 8
) (
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] in_q,
  output logic [W-1:0] rd_word
);
  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      assign rd_word[b] = dpc_pkg::merge_bit(dir_q[b], out_q[b], in_q[b]);
    end
  endgenerate
endmodule

// File: rtl/dpc_ready.sv
module dpc_ready (
  input  logic is_second,
  input  logic peer_bidir,
  input  logic peer_rdy,
  output logic rdy
);
  always_comb begin
    if (is_second && peer_bidir) rdy = peer_rdy;
    else                         rdy = 1'b0;
  end
endmodule

// File: rtl/dpc_port.sv
module dpc_port #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = dpc_pkg::DPC_SYNC_DEFAULT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_wr_en,
  input  logic         dir_wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_n,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic         is_second,
  input  logic         peer_bidir,
  input  logic         peer_rdy,
  output logic         rdy
);
  logic [W-1:0] dir_q, out_q, in_q;

  dpc_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .data_wr_en(data_wr_en), .dir_wr_en(dir_wr_en),
    .wr_data(wr_data), .dir_q(dir_q), .out_q(out_q)
  );

  dpc_in_sample #(.W(W), .STAGES(SYNC_STAGES)) u_in (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .pin_in(pin_in), .in_q(in_q)
  );

  dpc_merge #(.W(W)) u_merge (
    .dir_q(dir_q), .out_q(out_q), .in_q(in_q), .rd_word(rd_data)
  );

  dpc_ready u_rdy (
    .is_second(is_second), .peer_bidir(peer_bidir), .peer_rdy(peer_rdy), .rdy(rdy)
  );

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
endmodule

// File: rtl/dpc_port_chk.sv
module dpc_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         data_wr_en,
  input logic         dir_wr_en,
  input logic [W-1:0] wr_data,
  input logic         rd_n,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic         is_second,
  input logic         peer_bidir,
  input logic         peer_rdy,
  input logic         rdy
);
  assert_out_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(data_wr_en) |-> pin_out == $past(wr_data));

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(data_wr_en) |-> $stable(pin_out));

  assert_oe_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dir_wr_en) |-> pin_oe == ~$past(wr_data));

  assert_oe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dir_wr_en) |-> $stable(pin_oe));

  assert_merge_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & pin_oe) == (pin_out & pin_oe));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rd_n) && !$past(dir_wr_en)) |->
      ((rd_data & ~pin_oe) == ($past(rd_data) & ~pin_oe)));

  assert_rdy_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_second |-> !rdy);

  assert_rdy_second_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_second |-> (rdy == (peer_bidir && peer_rdy)));
endmodule

bind dpc_port dpc_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_wr_en(data_wr_en), .dir_wr_en(dir_wr_en),
  .wr_data(wr_data), .rd_n(rd_n), .rd_data(rd_data), .pin_out(pin_out),
  .pin_oe(pin_oe), .is_second(is_second), .peer_bidir(peer_bidir),
  .peer_rdy(peer_rdy), .rdy(rdy)
);

// File: tb/dpc_port_test.sv
`timescale 1ns/1ps
module dpc_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       data_wr_en = 1'b0, dir_wr_en = 1'b0, rd_n = 1'b1;
  logic [7:0] wr_data = '0, pin_in = '0;
  logic       is_second = 1'b0, peer_bidir = 1'b0, peer_rdy = 1'b0;
  logic [7:0] rd_data, pin_out, pin_oe;
  logic       rdy;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  dpc_port uut (
    .clk(clk), .rst_n(rst_n), .data_wr_en(data_wr_en), .dir_wr_en(dir_wr_en),
    .wr_data(wr_data), .rd_n(rd_n), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .is_second(is_second),
    .peer_bidir(peer_bidir), .peer_rdy(peer_rdy), .rdy(rdy)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic write_dir(input logic [7:0] v);
    @(negedge clk); dir_wr_en = 1'b1; wr_data = v;
    @(negedge clk); dir_wr_en = 1'b0;
  endtask

  task automatic write_data(input logic [7:0] v);
    @(negedge clk); data_wr_en = 1'b1; wr_data = v;
    @(negedge clk); data_wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] o, p;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 oe in reset", pin_oe, 8'h00);
    chk("R1 out in reset", pin_out, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 out", pin_out, 8'h00);
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 rdy", {7'b0, rdy}, 8'h00);

    // sweep over every direction pattern: R4, R2, R5
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dv;
      dv = 8'(d);
      write_dir(dv);
      chk("R4 oe", pin_oe, ~dv);
      o = 8'(d * 7 + 3);
      write_data(o);
      chk("R2 out", pin_out, o);
      for (int k = 0; k < 3; k++) begin
        p = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(d * 37 + 11);
        @(negedge clk); pin_in = p;
        repeat (3) @(negedge clk);
        chk("R5 merge", rd_data, (dv & p) | (~dv & o));
      end
    end

    // R3: strobes low, bus busy
    write_dir(8'h3C);
    write_data(8'h81);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); wr_data = 8'(i * 53 + 1);
    end
    @(negedge clk);
    chk("R3 out hold", pin_out, 8'h81);
    chk("R3 oe hold", pin_oe, 8'hC3);

    // R6: exact latency
    write_dir(8'hFF);
    @(negedge clk); pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'hA5;
    @(negedge clk); chk("R6 edge1", rd_data, 8'h00);
    @(negedge clk); chk("R6 edge2", rd_data, 8'h00);
    @(negedge clk); chk("R6 edge3", rd_data, 8'hA5);

    // R7: freeze while read strobe low
    pin_in = 8'h3C;
    repeat (3) @(negedge clk);
    rd_n = 1'b0; pin_in = 8'hC3;
    repeat (5) @(negedge clk);
    chk("R7 frozen", rd_data, 8'h3C);
    rd_n = 1'b1;
    @(negedge clk);
    chk("R7 reload", rd_data, 8'hC3);

    // R8: writes during a read
    rd_n = 1'b0;
    write_dir(8'h0F);
    chk("R8 oe", pin_oe, 8'hF0);
    write_data(8'h96);
    chk("R8 out", pin_out, 8'h96);
    chk("R8 rd", rd_data, 8'h93);
    rd_n = 1'b1;

    // R9 / R10: ready forcing
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      is_second = c[2]; peer_bidir = c[1]; peer_rdy = c[0];
      #2;
      if (!c[2]) chk("R9 rdy", {7'b0, rdy}, 8'h00);
      else       chk("R10 rdy", {7'b0, rdy}, {7'b0, c[1] & c[0]});
    end

    @(negedge clk);
    finish_run();
  end
endmodule